// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block lets a host fetch small configuration items, each identified by a 16-bit key, as a stream of bytes. The host first writes a key to the selector. It then reads the data register one or more times, and each read returns the next bytes of the chosen item. An internal byte offset tracks the position in the item. It starts at zero on every selection and stops at the item's end.

Items live in a fixed table with two banks, one generic and one architecture-local. Contents and lengths are computed when the design is elaborated. A read may ask for 1, 2, 4 or 8 bytes. The bytes are packed so that the earliest byte lands in the most significant position, and any shortfall at the end of an item is filled with zeros.

A parameter picks the register layout. In the split layout the selector and the data register are separate. In the combined layout one register carries both functions, and the access size decides which one is meant. Every request gets a response exactly one cycle later.

Top module: `cfgkey_port`

## Requirements
- R1: After reset the selection is bank 0, index 0 (the signature item) and the offset is 0, so the first 4-byte read returns 0x00010203.
- R2: Every accepted selector write sets the read offset to 0, including a reselection of the current item.
- R3: Key decoding: bit 14 chooses the bank (1 = architecture-local), bits 13:0 form the item index, and bit 15 has no effect.
- R4: An index of NUM_ITEMS or more makes the selection invalid, and every data read then returns zero without error.
- R5: A read of N bytes (size code 0/1/2/3 = 1/2/4/8 bytes) puts the first fetched byte in the most significant byte of the N-byte result, and the bytes above the N-byte field are zero.
- R6: If the item ends partway through a read, the remaining low-order bytes are zero and the offset stops at the item length.
- R7: When the offset is at or past the item length, or the item is empty, a read returns zero and the offset does not move.
- R8: A write to the data register is accepted without error and changes neither the selection nor the offset.
- R9: In the split layout (req_reg = 1 addresses the selector) only a 2-byte write is accepted. Any other selector access gets rsp_err = 1, returns zero data and changes no state.
- R10: In the combined layout a 1-byte access is a data access, a 2-byte write is a selector write, and every other access gets rsp_err = 1 with no state change.
- R11: rsp_valid is high exactly in the cycle after each cycle with req_valid high, and rsp_rdata and rsp_err belong to that request.
- R12: Table contents: the item in bank b at index i has length (5*i + 3*b + 4) mod (MAX_LEN+1). Its byte at offset k is (128*b + 16*i + k) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | Split layout: 1 = selector, 0 = data register; ignored in combined layout |
| req_size | input | 2 | Access size code: 0/1/2/3 = 1/2/4/8 bytes |
| req_wdata | input | 16 | Key for selector writes |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data, right-aligned N-byte field |
| rsp_err | output | 1 | Access rejected |

## Verification
A wrong offset appears at the very next read as shifted or repeated item bytes, so every read acts as a check on the offset. A wrong bank or index bit shows up as a foreign high nibble in the returned bytes, because each byte encodes its bank and index. A lost invalid flag shows up as nonzero data on the first read after an out-of-range key. A wrong clamp at the item end appears within two reads, as non-zero padding or as data read past the end.

// File: rtl/cfgkey_pkg.sv
package cfgkey_pkg;

    localparam int KEY_W    = 16;
    localparam int IDX_W    = 14;
    localparam int DATA_W   = 64;
    localparam int LANES    = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_SELECT,
        ACC_READ,
        ACC_DROP,
        ACC_REJECT
    } acc_kind_e;

    // Key layout: the bank bit sits above the index field.
    typedef struct packed {
        logic             spare;
        logic             bank;
        logic [IDX_W-1:0] index;
    } key_fields_t;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic              err;
    } rsp_t;

    function automatic logic [3:0] size_bytes(acc_size_e s);
        return 4'(1) << s;
    endfunction

    function automatic int item_len(int bank, int idx, int max_len);
        return (5 * idx + 3 * bank + 4) % (max_len + 1);
    endfunction

    function automatic logic [7:0] item_byte(int bank, int idx, int ofs);
        return 8'((128 * bank + 16 * idx + ofs) % 256);
    endfunction

endpackage

// File: rtl/cfgkey_decode.sv
module cfgkey_decode
    import cfgkey_pkg::*;
#(
    parameter bit COMBINED = 1'b0
) (
    input  logic      req_valid,
    input  logic      req_write,
    input  logic      req_reg,
    input  acc_size_e req_size,
    output acc_kind_e kind
);

    generate
        if (COMBINED) begin : g_comb
            always_comb begin
                kind = ACC_IDLE;
                if (req_valid) begin
                    if (req_size == SZ_B1)
                        kind = req_write ? ACC_DROP : ACC_READ;
                    else if (req_size == SZ_B2 && req_write)
                        kind = ACC_SELECT;
                    else
                        kind = ACC_REJECT;
                end
            end
            wire reg_sel_unused = req_reg;
        end else begin : g_split
            always_comb begin
                kind = ACC_IDLE;
                if (req_valid) begin
                    if (req_reg)
                        kind = (req_write && req_size == SZ_B2) ? ACC_SELECT : ACC_REJECT;
                    else
                        kind = req_write ? ACC_DROP : ACC_READ;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/cfgkey_rom.sv
module cfgkey_rom
    import cfgkey_pkg::*;
#(
    parameter int NUM_ITEMS = 8,
    parameter int MAX_LEN   = 16,
    parameter int ITEM_W    = $clog2(NUM_ITEMS),
    parameter int OFS_W     = $clog2(MAX_LEN + 1)
) (
    input  logic                    item_valid,
    input  logic                    item_bank,
    input  logic [ITEM_W-1:0]       item_idx,
    input  logic [OFS_W-1:0]        ofs,
    output logic [OFS_W-1:0]        len,
    output logic [LANES-1:0][7:0]   lane_byte
);

    localparam int SLOTS  = 2 * NUM_ITEMS;
    localparam int DEPTH  = SLOTS * MAX_LEN;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int POS_W  = OFS_W + 4;

    logic [7:0]       tbl  [DEPTH];
    logic [OFS_W-1:0] lens [SLOTS];

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign lens[s] = OFS_W'(item_len(s / NUM_ITEMS, s % NUM_ITEMS, MAX_LEN));
            for (genvar b = 0; b < MAX_LEN; b++) begin : g_byte
                assign tbl[s * MAX_LEN + b] = item_byte(s / NUM_ITEMS, s % NUM_ITEMS, b);
            end
        end
    endgenerate

    logic [SLOT_W-1:0] slot;
    assign slot = item_bank ? SLOT_W'(NUM_ITEMS) + SLOT_W'(item_idx) : SLOT_W'(item_idx);
    assign len  = item_valid ? lens[slot] : '0;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic [POS_W-1:0]  pos;
            logic [ADDR_W-1:0] addr;
            logic              live;
            assign pos  = POS_W'(ofs) + POS_W'(i);
            assign live = pos < POS_W'(len);
            assign addr = ADDR_W'(int'(slot) * MAX_LEN + int'(pos));
            assign lane_byte[i] = live ? tbl[addr] : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/cfgkey_sel.sv
module cfgkey_sel
    import cfgkey_pkg::*;
#(
    parameter int NUM_ITEMS = 8,
    parameter int ITEM_W    = $clog2(NUM_ITEMS),
    parameter int OFS_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_kind_e         kind,
    input  logic [KEY_W-1:0]  key,
    input  logic [3:0]        nbytes,
    input  logic [OFS_W-1:0]  cur_len,
    output logic              sel_valid,
    output logic              sel_bank,
    output logic [ITEM_W-1:0] sel_idx,
    output logic [OFS_W-1:0]  ofs
);

    localparam int SUM_W = OFS_W + 4;

    key_fields_t     kf;
    logic [SUM_W-1:0] sum;
    logic             in_item;

    assign kf      = key_fields_t'(key);
    assign sum     = SUM_W'(ofs) + SUM_W'(nbytes);
    assign in_item = ofs < cur_len;

    wire key_spare_unused = kf.spare;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_valid <= 1'b1;
            sel_bank  <= 1'b0;
            sel_idx   <= '0;
            ofs       <= '0;
        end else begin
            case (kind)
                ACC_SELECT: begin
                    ofs       <= '0;
                    sel_valid <= kf.index < IDX_W'(NUM_ITEMS);
                    sel_bank  <= kf.bank;
                    sel_idx   <= ITEM_W'(kf.index);
                end
                ACC_READ: begin
                    if (sel_valid && in_item) begin
                        if (sum > SUM_W'(cur_len))
                            ofs <= cur_len;
                        else
                            ofs <= OFS_W'(sum);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cfgkey_pack.sv
module cfgkey_pack
    import cfgkey_pkg::*;
(
    input  logic [LANES-1:0][7:0] lane_byte,
    input  logic [3:0]            nbytes,
    output logic [DATA_W-1:0]     packed_data
);

    always_comb begin
        packed_data = '0;
        for (int i = 0; i < LANES; i++) begin
            if (4'(i) < nbytes)
                packed_data[8 * (int'(nbytes) - 1 - i) +: 8] = lane_byte[i];
        end
    end

endmodule

// File: rtl/cfgkey_port.sv
module cfgkey_port
    import cfgkey_pkg::*;
#(
    parameter int NUM_ITEMS = 8,
    parameter int MAX_LEN   = 16,
    parameter bit COMBINED  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_reg,
    input  logic [1:0]        req_size,
    input  logic [KEY_W-1:0]  req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err
);

    localparam int ITEM_W = $clog2(NUM_ITEMS);
    localparam int OFS_W  = $clog2(MAX_LEN + 1);

    acc_kind_e             acc_kind;
    acc_size_e             size_code;
    logic [3:0]            nbytes;
    logic                  sel_valid;
    logic                  sel_bank;
    logic [ITEM_W-1:0]     sel_idx;
    logic [OFS_W-1:0]      cur_ofs;
    logic [OFS_W-1:0]      cur_len;
    logic [LANES-1:0][7:0] lane_byte;
    logic [DATA_W-1:0]     packed_data;
    rsp_t                  rsp_q;

    assign size_code = acc_size_e'(req_size);
    assign nbytes    = size_bytes(size_code);

    cfgkey_decode #(.COMBINED(COMBINED)) u_decode (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_reg   (req_reg),
        .req_size  (size_code),
        .kind      (acc_kind)
    );

    cfgkey_sel #(.NUM_ITEMS(NUM_ITEMS), .ITEM_W(ITEM_W), .OFS_W(OFS_W)) u_sel (
        .clk       (clk),
        .rst       (rst),
        .kind      (acc_kind),
        .key       (req_wdata),
        .nbytes    (nbytes),
        .cur_len   (cur_len),
        .sel_valid (sel_valid),
        .sel_bank  (sel_bank),
        .sel_idx   (sel_idx),
        .ofs       (cur_ofs)
    );

    cfgkey_rom #(.NUM_ITEMS(NUM_ITEMS), .MAX_LEN(MAX_LEN), .ITEM_W(ITEM_W), .OFS_W(OFS_W)) u_rom (
        .item_valid (sel_valid),
        .item_bank  (sel_bank),
        .item_idx   (sel_idx),
        .ofs        (cur_ofs),
        .len        (cur_len),
        .lane_byte  (lane_byte)
    );

    cfgkey_pack u_pack (
        .lane_byte   (lane_byte),
        .nbytes      (nbytes),
        .packed_data (packed_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q.valid <= req_valid;
            rsp_q.data  <= (acc_kind == ACC_READ) ? packed_data : '0;
            rsp_q.err   <= acc_kind == ACC_REJECT;
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_rdata = rsp_q.data;
    assign rsp_err   = rsp_q.err;

endmodule

// File: rtl/cfgkey_port_chk.sv
module cfgkey_port_chk
    import cfgkey_pkg::*;
#(
    parameter int OFS_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input acc_kind_e         kind,
    input logic [OFS_W-1:0]  ofs,
    input logic [OFS_W-1:0]  cur_len,
    input logic              cur_valid,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rsp_err
);

    AST_RESET_OFS_ZERO: assert property (@(posedge clk) rst |=> ofs == '0); // R1
    AST_SELECT_CLEARS_OFS: assert property (@(posedge clk) disable iff (rst)
        kind == ACC_SELECT |=> ofs == '0); // R2
    AST_INVALID_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_READ && !cur_valid) |=> rsp_rdata == '0); // R4
    AST_OFS_WITHIN_ITEM: assert property (@(posedge clk) disable iff (rst)
        cur_valid |-> ofs <= cur_len); // R6
    AST_EXHAUSTED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (kind == ACC_READ && ofs >= cur_len) |=> ($stable(ofs) && rsp_rdata == '0)); // R7
    AST_DATA_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        kind == ACC_DROP |=> ($stable(ofs) && !rsp_err)); // R8
    AST_REJECT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        kind == ACC_REJECT |=> (rsp_err && rsp_rdata == '0 && $stable(ofs))); // R9
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R11

endmodule

bind cfgkey_port cfgkey_port_chk #(.OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .kind      (acc_kind),
    .ofs       (cur_ofs),
    .cur_len   (cur_len),
    .cur_valid (sel_valid),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
);

// File: tb/cfgkey_port_tb.sv
module cfgkey_port_tb;

    localparam int NI = 8;
    localparam int ML = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rv   [2];
    logic        rw   [2];
    logic        rr   [2];
    logic [1:0]  rs   [2];
    logic [15:0] rk   [2];
    logic        ov   [2];
    logic [63:0] od   [2];
    logic        oe   [2];

    int n_chk  = 0;
    int n_fail = 0;

    int m_valid [2];
    int m_bank  [2];
    int m_idx   [2];
    int m_ofs   [2];

    always #5 clk = ~clk;

    cfgkey_port #(.NUM_ITEMS(NI), .MAX_LEN(ML), .COMBINED(1'b0)) u_dut (
        .clk(clk), .rst(rst), .req_valid(rv[0]), .req_write(rw[0]), .req_reg(rr[0]),
        .req_size(rs[0]), .req_wdata(rk[0]), .rsp_valid(ov[0]), .rsp_rdata(od[0]), .rsp_err(oe[0]));

    cfgkey_port #(.NUM_ITEMS(NI), .MAX_LEN(ML), .COMBINED(1'b1)) u_dut_cmb (
        .clk(clk), .rst(rst), .req_valid(rv[1]), .req_write(rw[1]), .req_reg(rr[1]),
        .req_size(rs[1]), .req_wdata(rk[1]), .rsp_valid(ov[1]), .rsp_rdata(od[1]), .rsp_err(oe[1]));

    function automatic int f_len(int b, int i);
        return (5 * i + 3 * b + 4) % (ML + 1);       // R12
    endfunction

    function automatic logic [7:0] f_byte(int b, int i, int k);
        return 8'((128 * b + 16 * i + k) % 256);     // R12
    endfunction

    task automatic check(input string req, input logic [63:0] got_d, input logic got_e,
                         input logic [63:0] exp_d, input logic exp_e);
        n_chk++;
        if (got_d !== exp_d || got_e !== exp_e) begin
            n_fail++;
            $display("FAIL %s: got data=%h err=%b, expected data=%h err=%b",
                     req, got_d, got_e, exp_d, exp_e);
        end
    endtask

    // Drive one access and predict its response from the requirements.
    task automatic op(input int w, input bit wr, input bit rg, input int sz,
                      input logic [15:0] key, input string req);
        logic [63:0] ed;
        logic        ee;
        int          kind; // 0 select, 1 read, 2 ignored write, 3 reject
        int          n;
        ed = '0;
        ee = 1'b0;
        n  = 1 << sz;
        if (w == 1) begin
            if (sz == 0)               kind = wr ? 2 : 1;   // R10
            else if (sz == 1 && wr)    kind = 0;
            else                       kind = 3;
        end else begin
            if (rg) kind = (wr && sz == 1) ? 0 : 3;         // R9
            else    kind = wr ? 2 : 1;                       // R8
        end
        case (kind)
            0: begin
                m_ofs[w]   = 0;
                m_bank[w]  = int'(key[14]);
                m_idx[w]   = int'(key[13:0]);
                m_valid[w] = (m_idx[w] < NI) ? 1 : 0;
            end
            1: begin
                if (m_valid[w] != 0) begin
                    for (int i = 0; i < n; i++) begin
                        ed = ed << 8;
                        if (m_ofs[w] < f_len(m_bank[w], m_idx[w])) begin
                            ed[7:0] = f_byte(m_bank[w], m_idx[w], m_ofs[w]);
                            m_ofs[w]++;
                        end
                    end
                end
            end
            3: ee = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        rv[w] = 1'b1; rw[w] = wr; rr[w] = rg; rs[w] = 2'(sz); rk[w] = key;
        @(negedge clk);
        rv[w] = 1'b0;
        n_chk++;
        if (ov[w] !== 1'b1) begin
            n_fail++;
            $display("FAIL R11: got rsp_valid=%b, expected 1", ov[w]);
        end
        check(req, od[w], oe[w], ed, ee);
    endtask

    task automatic run_all();
        for (int w = 0; w < 2; w++) begin
            rv[w] = 0; rw[w] = 0; rr[w] = 0; rs[w] = 0; rk[w] = 0;
            m_valid[w] = 1; m_bank[w] = 0; m_idx[w] = 0; m_ofs[w] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (ov[0] !== 1'b0 || ov[1] !== 1'b0) begin
            n_fail++;
            $display("FAIL R11: got idle rsp_valid=%b%b, expected 00", ov[0], ov[1]);
        end
        // split layout, directed
        op(0, 0, 0, 2, 16'h0, "R1");             // 0x00010203
        op(0, 0, 0, 0, 16'h0, "R7");             // past end
        op(0, 1, 1, 1, 16'h0001, "R2");
        op(0, 0, 0, 3, 16'h0, "R5");             // 0x1011121314151617
        op(0, 0, 0, 2, 16'h0, "R6");             // 0x18000000
        op(0, 0, 0, 1, 16'h0, "R7");
        op(0, 1, 1, 1, 16'h0001, "R2");
        op(0, 0, 0, 1, 16'h0, "R2");             // 0x1011
        op(0, 1, 0, 2, 16'h0, "R8");
        op(0, 0, 0, 0, 16'h0, "R8");             // 0x12
        op(0, 1, 1, 0, 16'h0002, "R9");
        op(0, 0, 1, 1, 16'h0002, "R9");
        op(0, 1, 1, 3, 16'h0002, "R9");
        op(0, 0, 0, 0, 16'h0, "R9");             // 0x13, state kept
        op(0, 1, 1, 1, 16'h4003, "R3");
        op(0, 0, 0, 3, 16'h0, "R3");             // 0xB0B1B2B3B4000000
        op(0, 1, 1, 1, 16'h8002, "R3");
        op(0, 0, 0, 1, 16'h0, "R3");             // 0x2021
        op(0, 1, 1, 1, 16'h0008, "R4");
        op(0, 0, 0, 3, 16'h0, "R4");
        op(0, 1, 1, 1, 16'h4100, "R4");
        op(0, 0, 0, 2, 16'h0, "R4");
        op(0, 1, 1, 1, 16'h0006, "R7");          // empty item
        op(0, 0, 0, 3, 16'h0, "R7");
        op(0, 1, 1, 1, 16'h400F, "R4");
        op(0, 0, 0, 0, 16'h0, "R4");
        // combined layout, directed
        op(1, 0, 0, 0, 16'h0, "R1");             // 0x00
        op(1, 1, 0, 1, 16'h0001, "R10");
        op(1, 0, 0, 0, 16'h0, "R10");            // 0x10
        op(1, 0, 0, 1, 16'h0, "R10");            // 2-byte read rejected
        op(1, 1, 0, 0, 16'h00FF, "R10");         // ignored write
        op(1, 0, 0, 0, 16'h0, "R10");            // 0x11
        op(1, 1, 0, 2, 16'h0002, "R10");
        op(1, 0, 0, 3, 16'h0, "R10");
        op(1, 0, 0, 0, 16'h0, "R10");            // 0x12
        // random mix, both layouts
        void'($urandom(32'h0C0F_F1E5));
        for (int t = 0; t < 600; t++) begin
            int w;
            int pick;
            logic [15:0] key;
            w    = int'($urandom % 2);
            pick = int'($urandom % 8);
            key  = {1'($urandom), 1'($urandom), 14'($urandom % 12)};
            if (pick < 2)
                op(w, 1, 1, (w == 1) ? 1 : 1, key, "R12");
            else if (pick < 6)
                op(w, 0, 0, (w == 1) ? 0 : int'($urandom % 4), key, "R12");
            else
                op(w, 1'($urandom), 1'($urandom), int'($urandom % 4), key, "R12");
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: got timeout, expected completion");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule